// File: doc/BRIEF.md
# Multi-Source Reset Controller with Fetch and Clock Traps

This block merges every reset cause of a small microcontroller into one active-low core reset. It takes four causes:
- an external reset pin, synchronised on the way in;
- a level from a watchdog counter;
- a trap on instruction fetches into protected address regions;
- a guard on writes to the clock-control register.

The trap and clock-guard causes produce a pulse of fixed length that is held by a down-counter. If a new cause arrives during a pulse, the pulse starts again at full length.

The fetch trap compares each valid fetch address with three inclusive address windows:
- the special-function register window, always protected;
- the debug register window, always protected;
- the RAM window, protected only while a RAM-trap enable is set.

A mode input selects what a trap does. It either causes a reset, or it raises a one-cycle interrupt request and captures the faulting address. The clock guard looks at each value written to the clock-control register. A write that would stop the clock the core is running on is turned into a reset. The oscillator is never stopped by this block; only the core logic is held in reset.

A sticky cause register has one bit per source. Software clears bits by writing ones to them. The external pin clears the register down to its own bit. All pins are plain control and status signals; nothing here carries a data stream, so there is no valid/ready handshake.

Top module: `rst_hub`

## Requirements
- R1: `core_rst_n` is low whenever any of these holds: `pin_rst_n` is low (no clock edge needed), `wdt_rst` is high (no clock edge needed), or a trap or clock-guard pulse is running.
- R2: When `pin_rst_n` rises, the pin's reset contribution ends at the third rising clock edge after the rise. This is two synchronising stages plus a one-cycle high-hold.
- R3: A fetch is protected when `fetch_valid` is 1 and `fetch_addr` lies in any of these windows, bounds inclusive:
  - special-function window 0x0000..0x003F;
  - debug window 0x0F80..0x0FFF;
  - RAM window 0x0040..0x083F, but only when `ram_trap_en` is 1.

  No other address is protected.
- R4: With `trap_irq_mode` = 0, a protected fetch makes `core_rst_n` low from the next rising edge, and `trap_irq` stays 0.
- R5: With `trap_irq_mode` = 1, a protected fetch does the following:
  - sets `trap_irq` high for the one cycle after the fetch edge;
  - loads `trap_addr` with the fetch address;
  - causes no reset.
- R6: `ck_wr_data` carries three fields:
  - bit 0: high-frequency oscillator enable;
  - bit 1: low-frequency oscillator enable;
  - bit 2: clock select, where 1 means the low-frequency clock.

  A write (`ck_wr_en` = 1) is unsafe when bit 0 is 0 and either bit 1 is 0 or bit 2 is 0. An unsafe write resets the core from the next edge; any other write has no effect.
- R7: A trap or clock-guard pulse keeps `core_rst_n` low for exactly RST_LEN cycles (default 24).
- R8: A new trap or clock-guard cause during a pulse restarts the count at RST_LEN.
- R9: `rst_cause` holds one bit per source and is updated at the edge after the cause:
  - bit 0: pin;
  - bit 1: watchdog;
  - bit 2: trap reset;
  - bit 3: clock guard.

  A set bit stays set until it is cleared.
- R10: A write with `cause_clr_wr` = 1 clears the bits that are 1 in `cause_clr_mask`; a set has priority over a clear in the same cycle. A pin reset forces `rst_cause` to 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_rst | input | 1 | Watchdog timeout level |
| fetch_valid | input | 1 | Instruction fetch in this cycle |
| fetch_addr | input | AW | Fetch address |
| ram_trap_en | input | 1 | Treat the RAM window as protected |
| trap_irq_mode | input | 1 | 1: a trap raises an interrupt; 0: a trap resets |
| ck_wr_en | input | 1 | Write to the clock-control register |
| ck_wr_data | input | 3 | Value written: {select, low enable, high enable} |
| cause_clr_wr | input | 1 | Cause-clear write strobe |
| cause_clr_mask | input | 4 | Cause bits to clear |
| core_rst_n | output | 1 | Internal core reset, active low |
| trap_irq | output | 1 | Trap interrupt request pulse |
| trap_addr | output | AW | Last trapped fetch address in interrupt mode |
| rst_cause | output | 4 | Sticky reset-cause bits |

## Verification
The hardest condition to reach from the ports is a second cause arriving in the middle of a running pulse, because the core is already held in reset at that point. The stimulus drives a protected fetch while `core_rst_n` is still low, ten cycles into a pulse. It then measures the remaining low time, which must be the full pulse length. The window edges are also hard to hit by chance, since each lies exactly one address away from an unprotected one. A vector table therefore walks each window's first and last address together with the address just outside it.

// File: rtl/rst_hub_pkg.sv
package rst_hub_pkg;
  localparam int NCAUSE    = 4;
  localparam int CAUSE_PIN = 0;
  localparam int CAUSE_WDT = 1;
  localparam int CAUSE_TRP = 2;
  localparam int CAUSE_CLK = 3;

  typedef struct packed {
    logic sel_lf;  // 1: core runs on the low-frequency clock
    logic lf_en;
    logic hf_en;
  } ckctl_t;
endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
  parameter int SYNC = 2,
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic pin_rst_n,
  output logic pin_rst
);
  localparam int N = SYNC + HOLD - 1;
  logic [N-1:0] chain;

  always_ff @(posedge clk or negedge pin_rst_n) begin
    if (!pin_rst_n) chain <= '0;
    else            chain <= {chain[N-2:0], 1'b1};
  end

  // released once the synchronised level has been high for HOLD cycles
  assign pin_rst = ~(&chain[N-1:SYNC-1]);
endmodule

// File: rtl/rst_fetch_trap.sv
module rst_fetch_trap #(
  parameter int              AW     = 16,
  parameter logic [AW-1:0]   SFR_LO = 16'h0000,
  parameter logic [AW-1:0]   SFR_HI = 16'h003F,
  parameter logic [AW-1:0]   RAM_LO = 16'h0040,
  parameter logic [AW-1:0]   RAM_HI = 16'h083F,
  parameter logic [AW-1:0]   DBG_LO = 16'h0F80,
  parameter logic [AW-1:0]   DBG_HI = 16'h0FFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          ram_trap_en,
  input  logic          irq_mode,
  output logic          trap_rst_req,
  output logic          trap_irq,
  output logic [AW-1:0] trap_addr
);
  localparam int NWIN = 3;
  localparam logic [AW-1:0] LO [NWIN] = '{SFR_LO, DBG_LO, RAM_LO};
  localparam logic [AW-1:0] HI [NWIN] = '{SFR_HI, DBG_HI, RAM_HI};

  logic [NWIN-1:0] win_en;
  logic [NWIN-1:0] win_hit;
  assign win_en = {ram_trap_en, 1'b1, 1'b1};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign win_hit[w] = win_en[w] && (fetch_addr >= LO[w]) && (fetch_addr <= HI[w]);
  end

  logic hit;
  assign hit          = fetch_valid && (|win_hit);
  assign trap_rst_req = hit && !irq_mode;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      trap_irq  <= 1'b0;
      trap_addr <= '0;
    end else begin
      trap_irq <= hit && irq_mode;
      if (hit && irq_mode) trap_addr <= fetch_addr;
    end
  end
endmodule

// File: rtl/rst_clk_guard.sv
module rst_clk_guard
  import rst_hub_pkg::*;
(
  input  logic   wr_en,
  input  ckctl_t wr_val,
  output logic   unsafe
);
  logic both_off, run_clk_off;
  assign both_off    = !wr_val.hf_en && !wr_val.lf_en;
  assign run_clk_off = !wr_val.hf_en && !wr_val.sel_lf;
  assign unsafe      = wr_en && (both_off || run_clk_off);
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int LEN = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              cnt <= '0;
    else if (go)          cnt <= CW'(LEN);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/rst_hub.sv
module rst_hub
  import rst_hub_pkg::*;
#(
  parameter int AW      = 16,
  parameter int RST_LEN = 24,
  parameter int SYNC    = 2,
  parameter int HOLD    = 2
) (
  input  logic          clk,
  input  logic          pin_rst_n,
  input  logic          wdt_rst,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          ram_trap_en,
  input  logic          trap_irq_mode,
  input  logic          ck_wr_en,
  input  logic [2:0]    ck_wr_data,
  input  logic          cause_clr_wr,
  input  logic [3:0]    cause_clr_mask,
  output logic          core_rst_n,
  output logic          trap_irq,
  output logic [AW-1:0] trap_addr,
  output logic [3:0]    rst_cause
);
  logic pin_rst, trap_req, clk_req, stretch_go, stretch_on;

  rst_pin_sync #(.SYNC(SYNC), .HOLD(HOLD)) u_pin (
    .clk(clk), .pin_rst_n(pin_rst_n), .pin_rst(pin_rst));

  rst_fetch_trap #(.AW(AW)) u_trap (
    .clk(clk), .rst(pin_rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .ram_trap_en(ram_trap_en), .irq_mode(trap_irq_mode),
    .trap_rst_req(trap_req), .trap_irq(trap_irq), .trap_addr(trap_addr));

  rst_clk_guard u_guard (
    .wr_en(ck_wr_en), .wr_val(ckctl_t'(ck_wr_data)), .unsafe(clk_req));

  assign stretch_go = trap_req || clk_req;

  rst_stretch #(.LEN(RST_LEN)) u_stretch (
    .clk(clk), .rst(pin_rst), .go(stretch_go), .active(stretch_on));

  assign core_rst_n = ~(pin_rst || !pin_rst_n || wdt_rst || stretch_on);

  logic [NCAUSE-1:0] set_vec, clr_vec;
  always_comb begin
    set_vec            = '0;
    set_vec[CAUSE_WDT] = wdt_rst;
    set_vec[CAUSE_TRP] = trap_req;
    set_vec[CAUSE_CLK] = clk_req;
    clr_vec            = cause_clr_wr ? cause_clr_mask : '0;
  end

  always_ff @(posedge clk or posedge pin_rst) begin
    if (pin_rst) rst_cause <= NCAUSE'(1) << CAUSE_PIN;
    else         rst_cause <= (rst_cause & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/rst_hub_chk.sv
module rst_hub_chk #(
  parameter int AW      = 16,
  parameter int RST_LEN = 24
) (
  input logic          clk,
  input logic          pin_rst_n,
  input logic          pin_rst,
  input logic          stretch_go,
  input logic          wdt_rst,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_addr,
  input logic          ram_trap_en,
  input logic          trap_irq_mode,
  input logic          ck_wr_en,
  input logic [2:0]    ck_wr_data,
  input logic          cause_clr_wr,
  input logic          core_rst_n,
  input logic          trap_irq,
  input logic [AW-1:0] trap_addr,
  input logic [3:0]    rst_cause
);
  logic prot;
  assign prot = fetch_valid &&
    ((fetch_addr <= AW'(16'h003F)) ||
     (fetch_addr >= AW'(16'h0F80) && fetch_addr <= AW'(16'h0FFF)) ||
     (ram_trap_en && fetch_addr >= AW'(16'h0040) && fetch_addr <= AW'(16'h083F)));

  logic [7:0] low_run;
  always_ff @(posedge clk or posedge pin_rst) begin
    if (pin_rst)                      low_run <= '0;
    else if (stretch_go)              low_run <= '0;
    else if (!core_rst_n && !wdt_rst) low_run <= low_run + 1'b1;
    else                              low_run <= '0;
  end

  AST_PIN_ASSERT: assert property (@(posedge clk) disable iff (pin_rst_n)
    !core_rst_n); // R1
  AST_WDT_RESET: assert property (@(posedge clk) disable iff (pin_rst)
    wdt_rst |-> !core_rst_n); // R1
  AST_PIN_RELEASE: assert property (@(posedge clk) disable iff (!pin_rst_n)
    $rose(core_rst_n) |-> $past(pin_rst_n) && !pin_rst); // R2
  AST_TRAP_RESET: assert property (@(posedge clk) disable iff (pin_rst)
    prot && !trap_irq_mode |=> !core_rst_n && !trap_irq); // R4
  AST_IRQ_CAPTURE: assert property (@(posedge clk) disable iff (pin_rst)
    trap_irq |-> $past(prot) && $past(trap_irq_mode) && trap_addr == $past(fetch_addr)); // R5
  AST_CLK_GUARD: assert property (@(posedge clk) disable iff (pin_rst)
    ck_wr_en && !ck_wr_data[0] && !(ck_wr_data[1] && ck_wr_data[2]) |=> !core_rst_n); // R6
  AST_STRETCH_MAX: assert property (@(posedge clk) disable iff (pin_rst)
    low_run <= 8'(RST_LEN)); // R7
  AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (pin_rst)
    !cause_clr_wr |=> (rst_cause & $past(rst_cause)) == $past(rst_cause)); // R9
  AST_CAUSE_PIN: assert property (@(posedge clk) disable iff (!pin_rst_n)
    pin_rst |-> rst_cause == 4'b0001); // R10
endmodule

bind rst_hub rst_hub_chk #(.AW(AW), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .pin_rst_n(pin_rst_n), .pin_rst(pin_rst), .stretch_go(stretch_go),
  .wdt_rst(wdt_rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .ram_trap_en(ram_trap_en), .trap_irq_mode(trap_irq_mode), .ck_wr_en(ck_wr_en),
  .ck_wr_data(ck_wr_data), .cause_clr_wr(cause_clr_wr), .core_rst_n(core_rst_n),
  .trap_irq(trap_irq), .trap_addr(trap_addr), .rst_cause(rst_cause));

// File: tb/rst_hub_tb.sv
`timescale 1ns/1ps
module rst_hub_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        pin_rst_n = 1'b0, wdt_rst = 1'b0, fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        ram_trap_en = 1'b0, trap_irq_mode = 1'b0, ck_wr_en = 1'b0;
  logic [2:0]  ck_wr_data = 3'b011;
  logic        cause_clr_wr = 1'b0;
  logic [3:0]  cause_clr_mask = '0;
  logic        core_rst_n, trap_irq;
  logic [15:0] trap_addr;
  logic [3:0]  rst_cause;

  rst_hub u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fetch(input logic [15:0] a);
    fetch_addr = a; fetch_valid = 1'b1;
    @(negedge clk); fetch_valid = 1'b0;
  endtask

  task automatic settle_clear();
    repeat (30) @(negedge clk);
    cause_clr_wr = 1'b1; cause_clr_mask = 4'b1111;
    @(negedge clk); cause_clr_wr = 1'b0;
  endtask

  function automatic int count_low();
    return 0;
  endfunction

  // {addr, ram_en, irq_mode, exp_reset, exp_irq}
  localparam logic [19:0] VEC [10] = '{
    {16'h0010, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h003F, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h0040, 1'b0, 1'b0, 1'b0, 1'b0},
    {16'h0040, 1'b1, 1'b0, 1'b1, 1'b0},
    {16'h083F, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h0840, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h0F80, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h0FFF, 1'b0, 1'b0, 1'b1, 1'b0},
    {16'h8000, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h0F7F, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 pin low holds reset", core_rst_n, 0);
    chk("R10 pin reset cause", rst_cause, 4'b0001);
    chk("R5 irq idle in reset", trap_irq, 0);
    pin_rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 still in reset after two edges", core_rst_n, 0);
    @(negedge clk);
    chk("R2 released at third edge", core_rst_n, 1);
    cause_clr_wr = 1'b1; cause_clr_mask = 4'b0001;
    @(negedge clk); cause_clr_wr = 1'b0;
    chk("R10 clear by mask", rst_cause, 4'b0000);

    // vector walk: R3 windows, R4 reset mode, R5 interrupt mode
    foreach (VEC[i]) begin
      ram_trap_en = VEC[i][3]; trap_irq_mode = VEC[i][2];
      fetch(VEC[i][19:4]);
      chk($sformatf("R3/R4 vec%0d reset", i), !core_rst_n, VEC[i][1]);
      chk($sformatf("R3/R5 vec%0d irq", i), trap_irq, VEC[i][0]);
      if (VEC[i][0]) chk($sformatf("R5 vec%0d addr", i), trap_addr, VEC[i][19:4]);
      @(negedge clk);
      if (VEC[i][0]) chk($sformatf("R5 vec%0d one-cycle", i), trap_irq, 0);
      chk($sformatf("R9 vec%0d trap cause", i), rst_cause[2], VEC[i][1]);
      settle_clear();
    end

    // R7 pulse length
    trap_irq_mode = 1'b0; ram_trap_en = 1'b0;
    fetch(16'h0020);
    n = 0;
    while (!core_rst_n && n < 100) begin n++; @(negedge clk); end
    chk("R7 pulse length", n, 24);
    settle_clear();

    // R8 restart during pulse
    fetch(16'h0020);
    repeat (9) @(negedge clk);
    chk("R8 still low before retrigger", core_rst_n, 0);
    fetch(16'h0FA0);
    n = 0;
    while (!core_rst_n && n < 100) begin n++; @(negedge clk); end
    chk("R8 restarted full length", n, 24);
    settle_clear();

    // R6 clock guard
    for (int k = 0; k < 5; k++) begin
      logic [2:0] d; logic en; logic ex;
      case (k)
        0: begin d = 3'b010; en = 1; ex = 1; end
        1: begin d = 3'b100; en = 1; ex = 1; end
        2: begin d = 3'b110; en = 1; ex = 0; end
        3: begin d = 3'b001; en = 1; ex = 0; end
        default: begin d = 3'b000; en = 0; ex = 0; end
      endcase
      ck_wr_data = d; ck_wr_en = en;
      @(negedge clk); ck_wr_en = 1'b0;
      chk($sformatf("R6 write %0b en %0b reset", d, en), !core_rst_n, ex);
      chk($sformatf("R9 write %0b clock cause", d), rst_cause[3], ex);
      settle_clear();
    end

    // R1 watchdog immediate, R9 cause
    wdt_rst = 1'b1; #1;
    chk("R1 watchdog immediate", core_rst_n, 0);
    @(negedge clk); wdt_rst = 1'b0; #1;
    chk("R1 watchdog release", core_rst_n, 1);
    chk("R9 watchdog cause", rst_cause, 4'b0010);

    // R9 sticky / R10 selective clear, empty clear
    fetch(16'h0001);
    repeat (3) @(negedge clk);
    chk("R9 sticky accumulate", rst_cause, 4'b0110);
    cause_clr_wr = 1'b1; cause_clr_mask = 4'b0000;
    @(negedge clk); cause_clr_wr = 1'b0;
    chk("R10 empty mask no effect", rst_cause, 4'b0110);
    cause_clr_wr = 1'b1; cause_clr_mask = 4'b0100;
    @(negedge clk); cause_clr_wr = 1'b0;
    chk("R10 clear only masked bit", rst_cause, 4'b0010);

    // R10 pin reset forces pin-only cause
    pin_rst_n = 1'b0; #1;
    chk("R1 pin async assert", core_rst_n, 0);
    @(negedge clk); pin_rst_n = 1'b1;
    chk("R10 pin clears others", rst_cause, 4'b0001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule